// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Converter Command Engine

This block sits behind a serial front end and turns already-assembled command frames into the state of four converter channels. Each frame carries a 4-bit operation, a 4-bit channel selector and a 16-bit data word. Every channel keeps a staging register and a live register. Only the live register drives the channel's output code. Each channel also has a sleep flag. Frames can stage a value, promote staged values to live, do both at once, promote every channel, or put channels to sleep. Each channel raises a busy output while it wakes from sleep. The wake time is counted in system clock cycles, and it is longer when the whole bank had been asleep.

Frames arrive on a valid/ready stream. The block never applies back-pressure: `cmd_ready` is high whenever the block is out of reset. Every cycle in which `cmd_valid` and `cmd_ready` are both high consumes exactly one frame, and its effect is visible on the outputs after that clock edge. The parameter `RES_BITS` (16, 14 or 12) sets how many leading data bits form a channel code. `MIDSCALE_RST` picks the reset code.

Top module: `quad_dac_ctrl`

## Requirements
- R1: Operation 4'b0000 loads the code into the staging register of the selected channel or channels. The live codes on `dac_code` do not change.
- R2: Operation 4'b0001 copies the staging register into the live register of the selected channel or channels and clears their sleep flags.
- R3: Operation 4'b0010 first loads the code into the selected staging register(s). It then copies staging to live on all four channels and clears all four sleep flags.
- R4: Operation 4'b0011 loads the code into both the staging and the live register of the selected channel(s) and clears their sleep flags.
- R5: Operation 4'b0100 sets the sleep flag of the selected channel(s). The data word is ignored, and neither the staging nor the live register changes.
- R6: Selector 4'h0 to 4'h3 picks channel 0 to 3, which is `dac_code` slice 0 (lowest bits) to slice 3. Selector 4'hF picks all four channels.
- R7: Operation 4'b1111 changes nothing, whatever the selector is.
- R8: Any other operation code, or any selector outside 0..3 and F with an operation other than 4'b1111, leaves all channel state unchanged. It also sets `cmd_error`, which stays high until reset.
- R9: A channel code is `cmd_data[15 -: RES_BITS]`. The remaining low data bits have no effect.
- R10: After reset, every staging and live register holds 2^(RES_BITS-1) when `MIDSCALE_RST` is 1, or 0 when it is 0. All sleep flags, busy outputs and `cmd_error` are low.
- R11: A frame that wakes a sleeping channel while at least one channel is awake holds that channel's busy high for exactly `SHORT_CYC` cycles, starting the cycle after the frame is accepted.
- R12: If all four channels were asleep when the waking frame was accepted, busy stays high for exactly `LONG_CYC` cycles instead.
- R13: A promote to an already awake channel raises no busy. Putting a waking channel back to sleep drops its busy at once. Busy is never high on a sleeping channel.
- R14: `cmd_ready` is high in every cycle out of reset, and each accepted beat is one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Frame beat valid |
| cmd_ready | output | 1 | Frame beat accepted when high with valid |
| cmd_op | input | 4 | Operation code |
| cmd_addr | input | 4 | Channel selector |
| cmd_data | input | 16 | Data word, code left-aligned |
| dac_code | output | 4*RES_BITS | Live codes, channel 0 in the low slice |
| dac_pd | output | 4 | Per-channel sleep flag |
| dac_busy | output | 4 | Per-channel wake settling in progress |
| cmd_error | output | 1 | Sticky flag for reserved codes |

## Verification
The bench stages a value and checks that the live code holds its old value until a promote. A design that merged the two registers would show the new code too early. It sends the stage-then-promote-all frame and checks that the selected channel gets the new data while every other channel gets its own staged value, which catches an engine that promotes before it writes. It puts the whole bank to sleep and then wakes one channel, then another, and times each busy pulse. This catches a delay choice that looks at the bank state after the frame instead of before it. It also sends reserved codes and checks that no register moved and that the error flag stays set.

// File: rtl/qdc_pkg.sv
`timescale 1ns/1ps
package qdc_pkg;
  localparam int NCH    = 4;
  localparam int DATA_W = 16;

  typedef enum logic [3:0] {
    OP_STAGE       = 4'b0000,
    OP_PROMOTE     = 4'b0001,
    OP_STAGE_ALL   = 4'b0010,
    OP_STAGE_PROM  = 4'b0011,
    OP_SLEEP       = 4'b0100,
    OP_IDLE        = 4'b1111
  } op_e;

  localparam logic [3:0] SEL_ALL = 4'hF;

  // Selector to channel mask; returns zero for reserved selectors.
  function automatic logic [NCH-1:0] sel_mask(input logic [3:0] sel);
    logic [NCH-1:0] m;
    m = '0;
    if (sel == SEL_ALL) m = '1;
    else if (sel < 4'(NCH)) m[sel[1:0]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/qdc_decode.sv
`timescale 1ns/1ps
module qdc_decode
  import qdc_pkg::*;
(
  input  logic           fire,
  input  logic [3:0]     op,
  input  logic [3:0]     sel,
  output logic [NCH-1:0] wr_mask,
  output logic [NCH-1:0] upd_mask,
  output logic [NCH-1:0] pd_mask,
  output logic           err_hit
);
  logic [NCH-1:0] m;
  logic           sel_ok;
  logic [NCH-1:0] wr_n, upd_n, pd_n;
  logic           bad_op;

  assign m      = sel_mask(sel);
  assign sel_ok = (m != '0);

  always_comb begin
    wr_n   = '0;
    upd_n  = '0;
    pd_n   = '0;
    bad_op = 1'b0;
    unique case (op)
      OP_STAGE:      wr_n = m;
      OP_PROMOTE:    upd_n = m;
      OP_STAGE_ALL:  begin wr_n = m; upd_n = '1; end
      OP_STAGE_PROM: begin wr_n = m; upd_n = m; end
      OP_SLEEP:      pd_n = m;
      OP_IDLE:       ;
      default:       bad_op = 1'b1;
    endcase
  end

  logic reject;
  assign reject   = bad_op || (op != OP_IDLE && !sel_ok);
  assign err_hit  = fire && reject;
  assign wr_mask  = (fire && !reject) ? wr_n  : '0;
  assign upd_mask = (fire && !reject) ? upd_n : '0;
  assign pd_mask  = (fire && !reject) ? pd_n  : '0;
endmodule

// File: rtl/qdc_channel.sv
`timescale 1ns/1ps
module qdc_channel #(
  parameter int RES_BITS     = 16,
  parameter bit MIDSCALE_RST = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic                upd,
  input  logic                pd_set,
  input  logic [RES_BITS-1:0] code_in,
  output logic [RES_BITS-1:0] live_q,
  output logic                pd_q
);
  localparam logic [RES_BITS-1:0] RST_CODE =
    MIDSCALE_RST ? (RES_BITS'(1) << (RES_BITS-1)) : '0;

  logic [RES_BITS-1:0] stage_q;
  logic [RES_BITS-1:0] stage_next;

  assign stage_next = wr ? code_in : stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= RST_CODE;
      live_q  <= RST_CODE;
      pd_q    <= 1'b0;
    end else begin
      stage_q <= stage_next;
      if (upd) begin
        live_q <= stage_next;
        pd_q   <= 1'b0;
      end else if (pd_set) begin
        pd_q <= 1'b1;
      end
    end
  end

  AST_WAKE_ON_PROMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !pd_q); // R2
  AST_SLEEP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    pd_set && !upd |=> pd_q); // R5
  AST_SLEEP_KEEPS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pd_set |=> $stable(live_q)); // R5
  AST_STAGE_KEEPS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !upd |=> $stable(live_q)); // R1
endmodule

// File: rtl/qdc_settle.sv
`timescale 1ns/1ps
module qdc_settle #(
  parameter int NCH       = 4,
  parameter int SHORT_CYC = 250,
  parameter int LONG_CYC  = 600
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pd_q,
  input  logic [NCH-1:0] upd_mask,
  input  logic [NCH-1:0] pd_mask,
  output logic [NCH-1:0] busy
);
  localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic all_down;
  assign all_down = &pd_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] cnt;
    logic          waking;
    assign waking = upd_mask[i] && pd_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n)               cnt <= '0;
      else if (pd_mask[i])      cnt <= '0;
      else if (waking)          cnt <= all_down ? CW'(LONG_CYC) : CW'(SHORT_CYC);
      else if (cnt != '0)       cnt <= cnt - 1'b1;
    end
    assign busy[i] = (cnt != '0);

    AST_BUSY_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
      busy[i] |-> !pd_q[i]); // R13
    AST_NO_BUSY_IF_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_mask[i] && !pd_q[i] && !busy[i] |=> !busy[i]); // R13
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(MAXC)); // R12
  end
endmodule

// File: rtl/quad_dac_ctrl.sv
`timescale 1ns/1ps
module quad_dac_ctrl
  import qdc_pkg::*;
#(
  parameter int RES_BITS     = 16,
  parameter bit MIDSCALE_RST = 1'b0,
  parameter int SHORT_CYC    = 250,
  parameter int LONG_CYC     = 600
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [3:0]              cmd_op,
  input  logic [3:0]              cmd_addr,
  input  logic [15:0]             cmd_data,
  output logic [4*RES_BITS-1:0]   dac_code,
  output logic [3:0]              dac_pd,
  output logic [3:0]              dac_busy,
  output logic                    cmd_error
);
  logic           fire;
  logic [NCH-1:0] wr_mask, upd_mask, pd_mask;
  logic           err_hit;
  logic [RES_BITS-1:0] code_in;

  assign cmd_ready = rst_n;
  assign fire      = cmd_valid && cmd_ready;
  assign code_in   = cmd_data[DATA_W-1 -: RES_BITS];

  qdc_decode u_dec (
    .fire     (fire),
    .op       (cmd_op),
    .sel      (cmd_addr),
    .wr_mask  (wr_mask),
    .upd_mask (upd_mask),
    .pd_mask  (pd_mask),
    .err_hit  (err_hit)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    qdc_channel #(.RES_BITS(RES_BITS), .MIDSCALE_RST(MIDSCALE_RST)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_mask[i]),
      .upd     (upd_mask[i]),
      .pd_set  (pd_mask[i]),
      .code_in (code_in),
      .live_q  (dac_code[i*RES_BITS +: RES_BITS]),
      .pd_q    (dac_pd[i])
    );
  end

  qdc_settle #(.NCH(NCH), .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd_q     (dac_pd),
    .upd_mask (upd_mask),
    .pd_mask  (pd_mask),
    .busy     (dac_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       cmd_error <= 1'b0;
    else if (err_hit) cmd_error <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_error |=> cmd_error); // R8
  AST_REJECT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |=> $stable(dac_code) && $stable(dac_pd)); // R8
  AST_IDLE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cmd_op == 4'b1111 |=> $stable(dac_code) && $stable(dac_pd)); // R7
  AST_READY_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready); // R14
endmodule

// File: tb/quad_dac_ctrl_test.sv
`timescale 1ns/1ps
module quad_dac_ctrl_test;
  localparam int RB = 12;
  localparam int SC = 20;
  localparam int LC = 50;
  localparam logic [RB-1:0] MID = 12'h800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [3:0] cmd_op = '0, cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic [4*RB-1:0] dac_code;
  logic [3:0] dac_pd, dac_busy;
  logic cmd_error;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  quad_dac_ctrl #(.RES_BITS(RB), .MIDSCALE_RST(1'b1), .SHORT_CYC(SC), .LONG_CYC(LC)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .dac_code(dac_code), .dac_pd(dac_pd), .dac_busy(dac_busy), .cmd_error(cmd_error)
  );

  typedef struct {
    logic [4*RB-1:0] code;
    logic [3:0]      pd;
    logic            err;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  logic [RB-1:0] st_m [4];
  logic [RB-1:0] lv_m [4];
  logic [3:0]    pd_m;
  logic          err_m;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [4*RB-1:0] pack_live();
    logic [4*RB-1:0] v;
    for (int i = 0; i < 4; i++) v[i*RB +: RB] = lv_m[i];
    return v;
  endfunction

  // Reference model of the frame rules, taken from the requirement list.
  task automatic model(input logic [3:0] op, input logic [3:0] sel, input logic [15:0] d);
    logic [3:0] m;
    logic [RB-1:0] c;
    c = d[15 -: RB];
    m = (sel == 4'hF) ? 4'hF : (sel < 4) ? (4'b1 << sel) : 4'h0;
    if (op == 4'hF) return;
    if (m == 0 || !(op inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h4})) begin
      err_m = 1'b1;
      return;
    end
    for (int i = 0; i < 4; i++) begin
      if (m[i] && op inside {4'h0, 4'h2, 4'h3}) st_m[i] = c;
    end
    for (int i = 0; i < 4; i++) begin
      if ((op == 4'h2) || (m[i] && op inside {4'h1, 4'h3})) begin
        lv_m[i] = st_m[i];
        pd_m[i] = 1'b0;
      end
      if (m[i] && op == 4'h4) pd_m[i] = 1'b1;
    end
  endtask

  task automatic send(input string tag, input logic [3:0] op, input logic [3:0] sel,
                      input logic [15:0] d);
    exp_t e;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = sel; cmd_data = d;
    model(op, sel, d);
    e.code = pack_live(); e.pd = pd_m; e.err = err_m; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  // Monitor: pops an expected snapshot for every accepted beat.
  initial begin
    forever begin
      @(posedge clk);
      if (cmd_valid && cmd_ready) begin
        exp_t e;
        #4;
        if (exp_q.size() == 0) begin
          chk("R14 unexpected beat", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk({e.tag, " code"}, 64'(dac_code), 64'(e.code));
          chk({e.tag, " pd"},   64'(dac_pd),   64'(e.pd));
          chk({e.tag, " err"},  64'(cmd_error), 64'(e.err));
        end
      end
    end
  end

  // Returns the number of consecutive busy cycles on channel ch after a frame.
  task automatic busy_len(input int ch, output int n);
    n = 0;
    @(negedge clk);
    while (dac_busy[ch] && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 4; i++) begin st_m[i] = MID; lv_m[i] = MID; end
    pd_m = '0; err_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset code", 64'(dac_code), 64'({4{MID}}));
    chk("R10 reset pd", 64'(dac_pd), 0);
    chk("R10 reset busy", 64'(dac_busy), 0);
    chk("R10 reset err", 64'(cmd_error), 0);
    chk("R14 ready", 64'(cmd_ready), 1);

    send("R1 stage ch0 live held", 4'h0, 4'h0, 16'h1234);
    send("R2 promote ch0", 4'h1, 4'h0, 16'hFFFF);
    send("R4 R9 stage+promote ch1 low bits dropped", 4'h3, 4'h1, 16'hABCF);
    send("R1 stage ch2", 4'h0, 4'h2, 16'h5550);
    send("R3 stage ch3 promote all", 4'h2, 4'h3, 16'h7777);
    send("R5 R6 sleep all data ignored", 4'h4, 4'hF, 16'hFFFF);
    chk("R13 no busy while asleep", 64'(dac_busy), 0);

    send("R12 wake ch2 from full sleep", 4'h1, 4'h2, 16'h0000);
    busy_len(2, n);
    chk("R12 long busy length", 64'(n), 64'(LC));
    chk("R13 other channels idle", 64'(dac_busy), 0);

    send("R11 wake ch0 with ch2 awake", 4'h1, 4'h0, 16'h0000);
    busy_len(0, n);
    chk("R11 short busy length", 64'(n), 64'(SC));

    send("R7 idle op", 4'hF, 4'h9, 16'h4321);
    send("R8 reserved op", 4'h5, 4'h0, 16'h1111);
    send("R8 reserved selector", 4'h0, 4'h7, 16'h2222);
    send("R8 error stays after good frame", 4'h0, 4'h1, 16'h3330);

    send("R6 stage all", 4'h0, 4'hF, 16'h9990);
    send("R6 promote all", 4'h1, 4'hF, 16'h0000);
    idle(LC + 5);

    send("R13 promote awake ch0", 4'h1, 4'h0, 16'h0000);
    @(negedge clk);
    chk("R13 no busy on awake promote", 64'(dac_busy), 0);

    send("R5 sleep ch1", 4'h4, 4'h1, 16'h0000);
    send("R11 wake ch1", 4'h1, 4'h1, 16'h0000);
    idle(3);
    chk("R11 ch1 busy during wake", 64'(dac_busy[1]), 1);
    send("R13 sleep ch1 mid wake", 4'h4, 4'h1, 16'h0000);
    @(negedge clk);
    chk("R13 busy cleared by sleep", 64'(dac_busy[1]), 0);
    chk("R14 ready still high", 64'(cmd_ready), 1);

    idle(2);
    chk("R14 all beats consumed", 64'(exp_q.size()), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule